// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block turns a byte stream into the transmit side of a media-independent interface. Bytes arrive on a valid/ready handshake that also carries an end-of-frame flag. The block drives a transmit-enable line and a 4-bit data bus, both on the transmit clock, which is an input. Each frame starts with a preamble and a start-of-frame delimiter, and the payload follows. CRC, collisions and the inter-frame gap are handled elsewhere.

A mode input is sampled when a frame starts and selects one of two lane formats. In the default format, one nibble is sent per clock. In the serial encoder-decoder format, one bit is sent per clock on bit 0 of the data bus. If the source has no byte ready when the next one is needed, the block stops the frame after the byte it is sending and raises a one-cycle error pulse.

Top module: `mii_tx_serializer`

## Requirements
- R1: After reset, and whenever no frame is being sent, `tx_en` is 0, `txd` is 0, `s_ready` is 0 and `underrun` is 0. `txd` is 0 in every cycle where `tx_en` is 0.
- R2: When `s_valid` is high in an idle cycle, `tx_en` goes high in the next clock cycle, together with the first preamble symbol. No byte is taken from the stream at that edge.
- R3: Every frame starts with seven bytes of 0x55 and then one byte of 0xD5. The payload bytes follow in the order they were accepted.
- R4: With `serial_mode` = 0 at frame start, each byte takes two cycles on `txd[3:0]`. Bits [3:0] are sent first, then bits [7:4].
- R5: With `serial_mode` = 1 at frame start, each byte takes eight cycles. Each cycle sends one bit on `txd[0]`, starting with bit 0, and `txd[3:1]` stays 0.
- R6: `serial_mode` is sampled only in the cycle a frame starts. Changes to it during a frame do not affect the symbols or the frame length.
- R7: `s_ready` is high only in the last symbol cycle of the delimiter, or in the last symbol cycle of a payload byte that was not flagged last. A byte is transferred on a clock edge where both `s_valid` and `s_ready` are high.
- R8: After the last symbol of the byte accepted with `s_last` = 1, `tx_en` is 0 in the next cycle and `underrun` stays 0. A complete frame of N payload bytes keeps `tx_en` high for (8+N)×2 cycles in nibble mode, or (8+N)×8 cycles in serial mode.
- R9: If `s_valid` is low in a cycle where `s_ready` is high, the frame ends after the current byte. In the next cycle `tx_en` is 0 and `underrun` is 1, and `underrun` stays high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Stream byte is the last of its frame |
| s_ready | output | 1 | Block takes the byte at the next edge |
| serial_mode | input | 1 | 1 selects the one-bit serial format, 0 selects nibbles |
| tx_en | output | 1 | Transmit enable |
| txd | output | 4 | Transmit data |
| underrun | output | 1 | One-cycle pulse when a frame was cut short |

## Verification
The hardest case to reach is an underrun at the seam between the delimiter and the first payload byte. The frame start needs a valid byte, but that byte is only taken 16 or 64 cycles later. The bench reaches this case by holding the source's valid high until it sees the enable rise, then dropping it with no byte delivered. Other frames drop valid after a chosen number of bytes, in both lane formats. During each frame the bench toggles the mode input at random, to show that only the value at the start counts.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } tx_state_e;
endpackage

// File: rtl/mii_tx_shifter.sv
// Holds the byte being sent and steps through its symbols.
module mii_tx_shifter #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              mode,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic              byte_end,
  output logic [NIB_W-1:0]  txd
);
  localparam int NIB_CNT = BYTE_W / NIB_W;
  localparam int POS_W   = $clog2(BYTE_W);

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              en;
  logic [NIB_W-1:0]  nib;

  assign byte_end = active && (pos_q == (mode ? POS_W'(BYTE_W-1) : POS_W'(NIB_CNT-1)));

  always_comb begin
    en     = ld | active;
    byte_d = byte_q;
    pos_d  = pos_q;
    if (ld) begin
      byte_d = ld_byte;
      pos_d  = '0;
    end else if (active) begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      pos_q  <= '0;
    end else if (en) begin
      byte_q <= byte_d;
      pos_q  <= pos_d;
    end
  end

  always_comb begin
    nib = '0;
    for (int i = 0; i < NIB_CNT; i++) begin
      if (pos_q == POS_W'(i)) nib = byte_q[i*NIB_W +: NIB_W];
    end
  end

  always_comb begin
    if (!active)   txd = '0;
    else if (mode) txd = {{(NIB_W-1){1'b0}}, byte_q[pos_q]};
    else           txd = nib;
  end
endmodule

// File: rtl/mii_tx_fsm.sv
// Frame sequencing: preamble count, byte fetch, end and underrun.
module mii_tx_fsm
  import mii_tx_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter int                PRE_BYTES = 7,
  parameter logic [BYTE_W-1:0] PRE_VAL   = 8'h55,
  parameter logic [BYTE_W-1:0] SFD_VAL   = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_last,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              serial_mode,
  input  logic              byte_end,
  output logic              s_ready,
  output logic              active,
  output logic              mode_q,
  output logic              ld,
  output logic [BYTE_W-1:0] ld_byte,
  output logic              underrun
);
  localparam int CNT_W = $clog2(PRE_BYTES + 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BYTES - 1);
  localparam logic [CNT_W-1:0] SFD_IDX  = CNT_W'(PRE_BYTES);

  tx_state_e       state_q, state_d;
  logic [CNT_W-1:0] pre_q, pre_d;
  logic            last_q, last_d, mode_d, unr_q, unr_d;

  assign active   = (state_q != ST_IDLE);
  assign underrun = unr_q;

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    last_d  = last_q;
    mode_d  = mode_q;
    unr_d   = 1'b0;
    ld      = 1'b0;
    ld_byte = PRE_VAL;
    s_ready = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (s_valid) begin
          state_d = ST_PRE;
          pre_d   = '0;
          last_d  = 1'b0;
          mode_d  = serial_mode;
          ld      = 1'b1;
        end
      end
      default: begin
        if (byte_end) begin
          if (state_q == ST_PRE && pre_q < PRE_LAST) begin
            pre_d = pre_q + 1'b1;
            ld    = 1'b1;
          end else if (state_q == ST_PRE && pre_q == PRE_LAST) begin
            pre_d   = SFD_IDX;
            ld      = 1'b1;
            ld_byte = SFD_VAL;
          end else if (state_q == ST_DATA && last_q) begin
            state_d = ST_IDLE;
          end else begin
            s_ready = 1'b1;
            if (s_valid) begin
              ld      = 1'b1;
              ld_byte = s_data;
              last_d  = s_last;
              state_d = ST_DATA;
            end else begin
              state_d = ST_IDLE;
              unr_d   = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      last_q  <= 1'b0;
      mode_q  <= 1'b0;
      unr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      last_q  <= last_d;
      mode_q  <= mode_d;
      unr_q   <= unr_d;
    end
  end
endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer #(
  parameter int                BYTE_W    = 8,
  parameter int                NIB_W     = 4,
  parameter int                PRE_BYTES = 7,
  parameter logic [BYTE_W-1:0] PRE_VAL   = 8'h55,
  parameter logic [BYTE_W-1:0] SFD_VAL   = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              serial_mode,
  output logic              tx_en,
  output logic [NIB_W-1:0]  txd,
  output logic              underrun
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              byte_end, ld, mode_q;
  logic [BYTE_W-1:0] ld_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  mii_tx_fsm #(
    .BYTE_W(BYTE_W), .PRE_BYTES(PRE_BYTES), .PRE_VAL(PRE_VAL), .SFD_VAL(SFD_VAL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .s_valid(s_valid), .s_last(s_last),
    .s_data(s_data), .serial_mode(serial_mode), .byte_end(byte_end),
    .s_ready(s_ready), .active(tx_en), .mode_q(mode_q), .ld(ld),
    .ld_byte(ld_byte), .underrun(underrun)
  );

  mii_tx_shifter #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .active(tx_en), .mode(mode_q), .ld(ld),
    .ld_byte(ld_byte), .byte_end(byte_end), .txd(txd)
  );
endmodule

// File: rtl/mii_tx_checker.sv
module mii_tx_checker #(
  parameter int               NIB_W     = 4,
  parameter logic [NIB_W-1:0] FIRST_NIB = 4'h5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             tx_en,
  input logic [NIB_W-1:0] txd,
  input logic             underrun,
  input logic             mode_q
);
  a_r1_txd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == '0);
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(s_valid));
  a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) && !mode_q |-> txd == FIRST_NIB);
  a_r5_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && mode_q |-> txd[NIB_W-1:1] == '0);
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && $past(tx_en) |-> $stable(mode_q));
  a_r7_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tx_en);
  a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !tx_en && $past(s_ready && !s_valid));
  a_r9_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
endmodule

bind mii_tx_serializer mii_tx_checker #(.NIB_W(NIB_W), .FIRST_NIB(PRE_VAL[NIB_W-1:0])) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .s_valid(s_valid), .s_ready(s_ready),
  .tx_en(tx_en), .txd(txd), .underrun(underrun), .mode_q(mode_q)
);

// File: tb/mii_tx_serializer_tb_top.sv
module mii_tx_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] s_data;
  logic       s_valid, s_last, s_ready, serial_mode, tx_en, underrun;
  logic [3:0] txd;
  int         vectors = 0;
  int         fails = 0;
  logic [7:0] frame_b [0:63];

  always #5 clk = ~clk;

  mii_tx_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .serial_mode(serial_mode), .tx_en(tx_en), .txd(txd),
    .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sym(input bit mode, input int k);
    int spb = mode ? 8 : 2;
    int b = k / spb;
    int p = k % spb;
    logic [7:0] v = (b < 7) ? 8'h55 : (b == 7) ? 8'hD5 : frame_b[b-8];
    return mode ? {3'b000, v[p]} : v[p*4 +: 4];
  endfunction

  task automatic run_frame(input int len, input int avail, input bit mode);
    int spb = mode ? 8 : 2;
    int n_send = (avail < len) ? avail : len;
    int idx = 0, sym = 0, waitc = 0;
    bit started = 0, took = 0;
    for (int i = 0; i < len; i++) frame_b[i] = 8'($urandom);
    serial_mode = mode;
    for (int guard = 0; guard < 3000; guard++) begin
      @(negedge clk);
      if (took) idx++;
      if (tx_en) begin
        int b = sym / spb;
        bit rdy_exp;
        if (!started) begin
          started = 1;
          chk(waitc == 1, "R2 start latency", waitc, 1);
        end
        chk(txd == exp_sym(mode, sym), (b < 8) ? "R3 preamble symbol" :
            (mode ? "R5 serial symbol (R6 mode toggled)" : "R4 nibble symbol (R6 mode toggled)"),
            int'(txd), int'(exp_sym(mode, sym)));
        rdy_exp = (sym % spb == spb - 1) && (b >= 7) && !((b - 8) == len - 1);
        chk(s_ready == rdy_exp, "R7 ready timing", int'(s_ready), int'(rdy_exp));
        sym++;
      end else if (started) begin
        chk(sym == (8 + n_send) * spb, "R6 R8 frame symbol count", sym, (8 + n_send) * spb);
        chk(idx == n_send, "R7 bytes taken", idx, n_send);
        chk(underrun == (avail < len), "R8 R9 underrun flag", int'(underrun), int'(avail < len));
        chk(txd == 4'h0, "R1 txd after frame", int'(txd), 0);
        break;
      end else begin
        chk(txd == 4'h0 && underrun == 1'b0, "R1 idle outputs", int'(txd), 0);
      end
      s_valid = !started || (idx < n_send);
      s_data  = (idx < len) ? frame_b[idx] : 8'h00;
      s_last  = (idx == len - 1);
      if (!started) waitc++;
      serial_mode = started ? 1'($urandom) : mode;
      took = s_valid && s_ready;
    end
    s_valid = 1'b0;
    s_last = 1'b0;
    serial_mode = 1'b0;
    @(negedge clk);
    chk(!tx_en && !underrun && txd == 4'h0, "R9 underrun single cycle / R1 idle", int'(underrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = 8'h00; serial_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_en && txd == 4'h0 && !s_ready && !underrun, "R1 reset state", int'(tx_en), 0);
    // directed corners
    run_frame(1, 1, 1'b0);
    run_frame(1, 1, 1'b1);
    run_frame(4, 0, 1'b0);   // R9: no byte at the delimiter boundary
    run_frame(3, 0, 1'b1);
    run_frame(5, 2, 1'b1);   // R9: mid-frame
    run_frame(64, 64, 1'b0);
    for (int f = 0; f < 30; f++) begin
      int len = 1 + int'($urandom % 24);
      int avail = ($urandom % 4 == 0) ? int'($urandom % len) : len;
      run_frame(len, avail, 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule